// File: doc/BRIEF.md
# Save-State Instruction Fault Checker

This block decides, before any memory is touched, which fault a 512-byte processor state-save operation must raise. The decode stage presents the current operating mode, two control-register bits (task-switched and emulation), the feature-present bit, a lock-prefix flag, the operand's effective address and segment kind, the current privilege level, the alignment-check enable and the canonical-address status, together with a request strobe.

One clock after the strobe, the block returns three results. The first is a valid strobe. The second is a one-hot vector that marks the single winning fault. The third is a compact fault code for that fault. The rules differ by mode:

- Real mode adds a 64 KiB range check over the whole 512-byte operand.
- 64-bit mode splits non-canonical addresses into stack-fault or general-protection.
- Virtual-8086 mode turns misalignment into alignment-check.
- Under user privilege with alignment checking on, a parameter picks which misalignments are reported as alignment-check in place of general-protection.

Page faults, other segment-limit checks and the store itself are handled elsewhere.

Top module: `save_fault_check`

## Requirements
- R1: While reset is held and on the cycle after it, `rsp_valid` is 0, `fault_vec` is 0 and `fault_code` is 0.
- R2: `rsp_valid` is 1 exactly in the cycle after a cycle with `req` high. After a cycle with `req` low, `rsp_valid`, `fault_vec` and `fault_code` are all 0.
- R3: A request with `feat_ok` low, or with `lock_pfx` high, reports invalid-opcode: code 1, vector bit 0.
- R4: A request with `cr_ts` or `cr_em` high reports device-not-available: code 2, vector bit 1.
- R5: In real mode (`mode`=0), a request reports general-protection (code 4, vector bit 3) in any of these cases:
  - `addr[3:0]` is nonzero.
  - Any address bit above bit 15 is set.
  - `addr[15:0]` exceeds 16'hFE00, so that address+511 passes FFFFh.
- R6: In protected (`mode`=2) and compatibility (`mode`=3) modes, a nonzero `addr[3:0]` reports general-protection, except where R8 applies. This holds whatever the segment kind.
- R7: In 64-bit mode (`mode`=4), a request with `canon_ok` low reports stack-fault if `seg_stack` is high, and general-protection otherwise. Stack-fault is code 3, vector bit 2. A nonzero `addr[3:0]` reports general-protection, except where R8 applies.
- R8: In modes 2, 3 and 4, a request is reported as alignment-check instead of general-protection when all three hold: `cpl`=3, `ac_en` high, and `addr[AC_ALIGN_LOG2-1:0]` nonzero. Alignment-check is code 5, vector bit 4. With the default AC_ALIGN_LOG2=1, only odd addresses qualify; an even but not 16-byte-aligned address still gives general-protection.
- R9: In virtual-8086 mode (`mode`=1), a nonzero `addr[3:0]` reports alignment-check. No range check or general-protection applies in this mode.
- R10: When several faults apply, only the highest-priority one is reported. The order is invalid-opcode, device-not-available, stack-fault, general-protection, alignment-check. `fault_vec` is one-hot on that fault, and `fault_code` is its bit index plus one. A fault-free request gives code 0 and an all-zero vector.
- R11: Mode codes 5 to 7 raise no mode-dependent fault. Only R3 and R4 apply to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Check request strobe |
| mode | input | 3 | 0 real, 1 virtual-8086, 2 protected, 3 compatibility, 4 64-bit |
| cr_ts | input | 1 | Task-switched control bit |
| cr_em | input | 1 | Emulation control bit |
| feat_ok | input | 1 | Save-state feature present |
| lock_pfx | input | 1 | Lock prefix seen |
| addr | input | ADDR_W | Effective address of the operand |
| seg_stack | input | 1 | Access goes through the stack segment |
| cpl | input | 2 | Current privilege level |
| ac_en | input | 1 | Alignment checking enabled |
| canon_ok | input | 1 | Address is canonical |
| rsp_valid | output | 1 | Result valid |
| fault_vec | output | 5 | One-hot winning fault (UD, NM, SS, GP, AC from bit 0) |
| fault_code | output | 3 | Encoded winning fault, 0 for none |

## Verification
The assertions assume that the request inputs are stable over the sampling edge, and that `canon_ok` is a meaningful flag only in 64-bit mode. They also assume that reserved mode codes may appear and must stay fault-free apart from R3 and R4. The stimulus drives every input on the falling edge. It mostly draws mode codes 0 to 4, with occasional codes 5 to 7. It biases addresses toward the low four bits and toward the top of the 64 KiB window, so that the alignment, range and alignment-check boundaries are hit often.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam int NFAULT = 5;

    typedef enum logic [2:0] {
        MD_REAL   = 3'd0,
        MD_V86    = 3'd1,
        MD_PROT   = 3'd2,
        MD_COMPAT = 3'd3,
        MD_LONG   = 3'd4
    } mode_e;

    // Fault index in the vector; the code is the index plus one.
    localparam int FI_UD = 0;
    localparam int FI_NM = 1;
    localparam int FI_SS = 2;
    localparam int FI_GP = 3;
    localparam int FI_AC = 4;

    typedef enum logic [2:0] {
        FC_NONE = 3'd0,
        FC_UD   = 3'd1,
        FC_NM   = 3'd2,
        FC_SS   = 3'd3,
        FC_GP   = 3'd4,
        FC_AC   = 3'd5
    } fcode_e;

    localparam logic [15:0] OPND_LAST = 16'd511;

    // True when a 512-byte operand starting at a16 runs past FFFFh.
    function automatic logic beyond_64k(input logic [15:0] a16);
        return a16 > (16'hFFFF - OPND_LAST);
    endfunction

    typedef struct packed {
        logic ss;
        logic gp;
        logic ac;
    } mode_flt_t;

endpackage

// File: rtl/sfc_mode_rules.sv
module sfc_mode_rules
    import sfc_pkg::*;
#(
    parameter int ADDR_W        = 64,
    parameter int AC_ALIGN_LOG2 = 1
) (
    input  logic [2:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              seg_stack,
    input  logic [1:0]        cpl,
    input  logic              ac_en,
    input  logic              canon_ok,
    output mode_flt_t         flt
);
    localparam logic [3:0] AC_MASK = 4'((1 << AC_ALIGN_LOG2) - 1);

    logic misal, ac_pick, upper_set;

    assign misal     = addr[3:0] != 4'd0;
    assign ac_pick   = (cpl == 2'd3) && ac_en && ((addr[3:0] & AC_MASK) != 4'd0);
    assign upper_set = |addr[ADDR_W-1:16];

    always_comb begin
        flt = '0;
        case (mode_e'(mode))
            MD_REAL: begin
                flt.gp = misal || upper_set || beyond_64k(addr[15:0]);
            end
            MD_V86: begin
                flt.ac = misal;
            end
            MD_PROT, MD_COMPAT: begin
                flt.ac = misal && ac_pick;
                flt.gp = misal && !ac_pick;
            end
            MD_LONG: begin
                flt.ss = !canon_ok && seg_stack;
                flt.gp = (!canon_ok && !seg_stack) || (misal && !ac_pick);
                flt.ac = misal && ac_pick;
            end
            default: flt = '0;
        endcase
    end
endmodule

// File: rtl/sfc_prio.sv
module sfc_prio
    import sfc_pkg::*;
(
    input  logic [NFAULT-1:0] raw,
    output logic [NFAULT-1:0] win,
    output logic [2:0]        code
);
    always_comb begin
        win  = '0;
        code = FC_NONE;
        for (int i = NFAULT - 1; i >= 0; i--) begin
            if (raw[i]) begin
                win  = '0;
                win[i] = 1'b1;
                code = 3'(i + 1);
            end
        end
    end
endmodule

// File: rtl/save_fault_check.sv
module save_fault_check
    import sfc_pkg::*;
#(
    parameter int ADDR_W        = 64,
    parameter int AC_ALIGN_LOG2 = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [2:0]        mode,
    input  logic              cr_ts,
    input  logic              cr_em,
    input  logic              feat_ok,
    input  logic              lock_pfx,
    input  logic [ADDR_W-1:0] addr,
    input  logic              seg_stack,
    input  logic [1:0]        cpl,
    input  logic              ac_en,
    input  logic              canon_ok,
    output logic              rsp_valid,
    output logic [4:0]        fault_vec,
    output logic [2:0]        fault_code
);
    mode_flt_t         mflt;
    logic [NFAULT-1:0] raw, win;
    logic [2:0]        code_c;

    sfc_mode_rules #(.ADDR_W(ADDR_W), .AC_ALIGN_LOG2(AC_ALIGN_LOG2)) u_rules (
        .mode(mode), .addr(addr), .seg_stack(seg_stack), .cpl(cpl),
        .ac_en(ac_en), .canon_ok(canon_ok), .flt(mflt)
    );

    always_comb begin
        raw        = '0;
        raw[FI_UD] = !feat_ok || lock_pfx;
        raw[FI_NM] = cr_ts || cr_em;
        raw[FI_SS] = mflt.ss;
        raw[FI_GP] = mflt.gp;
        raw[FI_AC] = mflt.ac;
    end

    sfc_prio u_prio (.raw(raw), .win(win), .code(code_c));

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            fault_vec  <= '0;
            fault_code <= FC_NONE;
        end else begin
            rsp_valid  <= req;
            fault_vec  <= req ? win : '0;
            fault_code <= req ? code_c : FC_NONE;
        end
    end

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !req |=> (!rsp_valid && fault_vec == '0 && fault_code == 3'd0));
    p_req_valid_r2: assert property (@(posedge clk) disable iff (rst)
        req |=> rsp_valid);
    p_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fault_vec));
    p_code_matches_r10: assert property (@(posedge clk) disable iff (rst)
        (fault_code == 3'd0) == (fault_vec == '0));
    p_ud_first_r3: assert property (@(posedge clk) disable iff (rst)
        (req && (!feat_ok || lock_pfx)) |=> (fault_code == FC_UD));
    p_nm_second_r4: assert property (@(posedge clk) disable iff (rst)
        (req && feat_ok && !lock_pfx && (cr_ts || cr_em)) |=> (fault_code == FC_NM));
    p_v86_no_gp_r9: assert property (@(posedge clk) disable iff (rst)
        (req && mode == 3'd1) |=> (!fault_vec[FI_GP] && !fault_vec[FI_SS]));
    p_reserved_mode_r11: assert property (@(posedge clk) disable iff (rst)
        (req && mode > 3'd4) |=> (fault_vec[4:2] == 3'b000));
endmodule

// File: tb/save_fault_check_bench.sv
module save_fault_check_bench;
    localparam int ADDR_W = 64;

    logic              clk = 1'b0;
    logic              rst;
    logic              req;
    logic [2:0]        mode;
    logic              cr_ts, cr_em, feat_ok, lock_pfx, seg_stack, ac_en, canon_ok;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        cpl;
    logic              rsp_valid;
    logic [4:0]        fault_vec;
    logic [2:0]        fault_code;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    save_fault_check #(.ADDR_W(ADDR_W), .AC_ALIGN_LOG2(1)) u_save_fault_check (
        .clk(clk), .rst(rst), .req(req), .mode(mode), .cr_ts(cr_ts), .cr_em(cr_em),
        .feat_ok(feat_ok), .lock_pfx(lock_pfx), .addr(addr), .seg_stack(seg_stack),
        .cpl(cpl), .ac_en(ac_en), .canon_ok(canon_ok),
        .rsp_valid(rsp_valid), .fault_vec(fault_vec), .fault_code(fault_code)
    );

    // Expected code from the requirements (0 none, 1 UD, 2 NM, 3 SS, 4 GP, 5 AC).
    function automatic logic [2:0] exp_code();
        logic mis, acp;
        mis = addr[3:0] != 4'd0;
        acp = (cpl == 2'd3) && ac_en && addr[0];
        if (!feat_ok || lock_pfx) return 3'd1;                  // R3
        if (cr_ts || cr_em) return 3'd2;                       // R4
        case (mode)
            3'd0: if (mis || addr[63:16] != 0 || addr[15:0] > 16'hFE00) return 3'd4; // R5
            3'd1: if (mis) return 3'd5;                        // R9
            3'd2, 3'd3: if (mis) return acp ? 3'd5 : 3'd4;      // R6, R8
            3'd4: begin                                        // R7, R8
                if (!canon_ok) return seg_stack ? 3'd3 : 3'd4;
                if (mis) return acp ? 3'd5 : 3'd4;
            end
            default: ;                                         // R11
        endcase
        return 3'd0;
    endfunction

    task automatic check(input string tag, input logic ev, input logic [2:0] ec);
        logic [4:0] evec;
        evec = (ec == 0) ? 5'd0 : (5'd1 << (ec - 1));
        n_run++;
        if (rsp_valid !== ev || fault_code !== ec || fault_vec !== evec) begin
            n_fail++;
            $display("FAIL %s: valid=%0b code=%0d vec=%b expected valid=%0b code=%0d vec=%b",
                     tag, rsp_valid, fault_code, fault_vec, ev, ec, evec);
        end
    endtask

    task automatic set_clean(input logic [2:0] m, input logic [63:0] a);
        mode = m; addr = a; cr_ts = 0; cr_em = 0; feat_ok = 1; lock_pfx = 0;
        seg_stack = 0; cpl = 0; ac_en = 0; canon_ok = 1;
    endtask

    // Drive one request on a falling edge, check one cycle later.
    task automatic run_req(input string tag);
        logic [2:0] ec;
        req = 1'b1;
        ec = exp_code();
        @(negedge clk);
        req = 1'b0;
        check(tag, 1'b1, ec);
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5AFE_0C01;
        void'($urandom(seed));
        rst = 1; req = 0; set_clean(3'd2, 64'h0);
        @(negedge clk); @(negedge clk);
        check("R1 reset", 1'b0, 3'd0);
        rst = 0;
        @(negedge clk);
        check("R1 after reset", 1'b0, 3'd0);

        set_clean(3'd2, 64'h1000); run_req("R2 clean request");
        @(negedge clk); check("R2 idle", 1'b0, 3'd0);
        set_clean(3'd2, 64'h1003); lock_pfx = 1; cr_ts = 1; run_req("R3 lock wins");
        set_clean(3'd4, 64'h7); feat_ok = 0; canon_ok = 0; run_req("R3 no feature");
        set_clean(3'd0, 64'hFFF0); cr_em = 1; run_req("R4 emulation");
        set_clean(3'd0, 64'hFE00); run_req("R5 last fitting address");
        set_clean(3'd0, 64'hFE10); run_req("R5 past 64K");
        set_clean(3'd0, 64'h1_0000); run_req("R5 upper bits");
        set_clean(3'd0, 64'h0008); run_req("R5 misaligned");
        set_clean(3'd3, 64'h2004); seg_stack = 1; run_req("R6 compat misaligned");
        set_clean(3'd4, 64'h40); canon_ok = 0; seg_stack = 1; run_req("R7 stack fault");
        set_clean(3'd4, 64'h41); canon_ok = 0; cpl = 3; ac_en = 1; run_req("R7 gp beats ac R10");
        set_clean(3'd2, 64'h101); cpl = 3; ac_en = 1; run_req("R8 odd to AC");
        set_clean(3'd2, 64'h102); cpl = 3; ac_en = 1; run_req("R8 even stays GP");
        set_clean(3'd4, 64'h105); cpl = 2; ac_en = 1; run_req("R8 cpl2 gives GP");
        set_clean(3'd1, 64'hFFF8); run_req("R9 v86 misaligned");
        set_clean(3'd1, 64'hFFF0); run_req("R9 v86 no range check");
        set_clean(3'd6, 64'h3); canon_ok = 0; run_req("R11 reserved mode");

        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom % 16;
            mode     = (r < 14) ? 3'(r % 5) : 3'(5 + r % 3);
            feat_ok  = ($urandom % 10) != 0;
            lock_pfx = ($urandom % 10) == 0;
            cr_ts    = ($urandom % 8) == 0;
            cr_em    = ($urandom % 8) == 0;
            seg_stack = 1'($urandom);
            cpl      = 2'($urandom);
            ac_en    = 1'($urandom);
            canon_ok = ($urandom % 4) != 0;
            case ($urandom % 3)
                0: addr = {48'h0, 16'hFDF0 + 16'($urandom % 64)};
                1: addr = {$urandom, $urandom} & 64'hFFFF_FFFF_FFFF_FFF0 | 64'($urandom % 16);
                default: addr = 64'($urandom % 32'h1_0000);
            endcase
            if ($urandom % 4 == 0) begin
                @(negedge clk);
                check("R2 random idle", 1'b0, 3'd0);
            end else begin
                run_req("R10 random");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule